// File: doc/BRIEF.md
# DMA Request Boundary Splitter

This block turns one large DMA transfer request into a series of PCI Express memory request chunks. A request carries a byte start address, a total length counted in DWORDs and a direction flag (write or read). The block then emits chunks one at a time over a valid/ready handshake. Each chunk carries an address, a DWORD length, the direction and a flag that marks the final chunk.

Each chunk is sized as the smallest of three quantities. The first is the DWORDs still owed. The second is the size cap for the request's direction: the maximum payload size for writes, or the maximum read request size for reads. The third is the DWORDs left before the next 4 KB address boundary. After each accepted chunk the block moves the address forward by that chunk's byte count on its own. When the final chunk is taken, the block becomes ready for the next request.

The two size caps arrive as 3-bit codes and are captured together with the request. Header building, payload data, tags and completion matching belong to other blocks.

Top module: `dma_req_splitter`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and `chk_valid` is 0.
- R2: For a write request, no chunk is longer than the payload cap. Code n (0 to 5) means 32 << n DWORDs, and codes 6 and 7 mean 1024 DWORDs.
- R3: For a read request, no chunk is longer than the read request cap, decoded with the same code rule as R2.
- R4: No chunk crosses a 4 KB boundary: address bits [11:2] plus the chunk length is at most 1024.
- R5: Every chunk length equals the minimum of the remaining DWORDs, the direction's cap and the DWORDs left to the next 4 KB boundary.
- R6: The first chunk's address is the request address with bits [1:0] forced to 0. Each following chunk's address is the previous address plus 4 times the previous length.
- R7: `chk_last` is 1 exactly on the chunk whose length equals the remaining DWORDs. After that chunk is taken, the next cycle shows `req_ready` = 1 and `chk_valid` = 0. The chunk lengths add up to the request length.
- R8: A request is taken only on a cycle with `req_valid` and `req_ready` both 1. While chunks are pending, `req_ready` is 0 and the request inputs have no effect on the chunks.
- R9: A request of length 0 produces no chunk, and `req_ready` is 1 again on the next cycle.
- R10: While `chk_valid` is 1 and `chk_ready` is 0, the chunk outputs hold their values on the next cycle.
- R11: The size cap codes and the direction are captured when the request is taken. Later changes on those inputs do not alter the chunks of that request.
- R12: `chk_is_write` equals the direction of the request being split.
- R13: The first chunk is offered on the cycle after the request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Byte start address (DWORD aligned) |
| req_len_dw | input | LEN_W | Total length in DWORDs |
| req_is_write | input | 1 | 1 = memory write, 0 = memory read |
| max_payload_code | input | 3 | Write size cap code |
| max_read_code | input | 3 | Read size cap code |
| chk_valid | output | 1 | Chunk offered |
| chk_ready | input | 1 | Downstream takes the chunk |
| chk_addr | output | ADDR_W | Chunk byte address |
| chk_len_dw | output | 11 | Chunk length in DWORDs (1 to 1024) |
| chk_is_write | output | 1 | Chunk direction |
| chk_last | output | 1 | Final chunk of the request |

## Verification
The bench builds the block with a 16-bit address and a 12-bit length. This keeps every request short enough to walk chunk by chunk, while lengths of up to 1500 DWORDs still force many cap-limited and boundary-limited chunks. Every cap code, including the clamped codes 6 and 7, is swept in both directions. These codes are combined with start addresses just below, on and away from a 4 KB boundary, and with lengths of 0, 1, one below a cap, exactly a cap, one past a cap and above a boundary span. Downstream stalls and request inputs toggled mid-transfer show that held chunks stay put and that captured settings cannot be disturbed.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

    localparam int CODE_W      = 3;
    localparam int BASE_DW     = 32;
    localparam int MAX_CODE    = 5;
    localparam int BOUNDARY_DW = 1024;
    localparam int OFS_W       = $clog2(BOUNDARY_DW);
    localparam int CHUNK_W     = OFS_W + 1;

    typedef logic [CHUNK_W-1:0] chunk_len_t;
    typedef logic [CODE_W-1:0]  size_code_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } split_state_e;

    typedef struct packed {
        logic       is_write;
        size_code_t payload_code;
        size_code_t read_code;
    } split_cfg_t;

    // Decode a size cap code into DWORDs; codes beyond MAX_CODE clamp to 4 KB.
    function automatic chunk_len_t code_to_dw(input size_code_t code);
        if (code > size_code_t'(MAX_CODE))
            return chunk_len_t'(BOUNDARY_DW);
        return chunk_len_t'(BASE_DW) << code;
    endfunction

endpackage

// File: rtl/split_limit_sel.sv
module split_limit_sel
    import dma_split_pkg::*;
(
    input  split_cfg_t cfg,
    output chunk_len_t limit_dw
);
    chunk_len_t payload_dw;
    chunk_len_t read_dw;

    always_comb begin
        payload_dw = code_to_dw(cfg.payload_code);
        read_dw    = code_to_dw(cfg.read_code);
        limit_dw   = cfg.is_write ? payload_dw : read_dw;
    end
endmodule

// File: rtl/split_sizer.sv
module split_sizer
    import dma_split_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [LEN_W-1:0]  remain_dw,
    input  chunk_len_t        limit_dw,
    output chunk_len_t        chunk_dw,
    output logic              is_last
);
    localparam int CMP_W = (LEN_W > CHUNK_W) ? LEN_W : CHUNK_W;

    logic [OFS_W-1:0] dw_offset;
    logic [CMP_W-1:0] to_edge;
    logic [CMP_W-1:0] rem_x;
    logic [CMP_W-1:0] lim_x;
    logic [CMP_W-1:0] cap_min;
    logic [CMP_W-1:0] pick;

    always_comb begin
        dw_offset = cur_addr[OFS_W+1:2];
        to_edge   = CMP_W'(BOUNDARY_DW) - CMP_W'(dw_offset);
        rem_x     = CMP_W'(remain_dw);
        lim_x     = CMP_W'(limit_dw);
        cap_min   = (lim_x < to_edge) ? lim_x : to_edge;
        pick      = (rem_x < cap_min) ? rem_x : cap_min;
        chunk_dw  = chunk_len_t'(pick);
        is_last   = (rem_x == pick);
    end
endmodule

// File: rtl/split_ctrl.sv
module split_ctrl
    import dma_split_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  split_cfg_t        req_cfg,
    input  logic              chk_ready,
    input  chunk_len_t        chunk_dw,
    input  logic              is_last,
    output logic              req_ready,
    output logic              chk_valid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LEN_W-1:0]  remain_dw,
    output split_cfg_t        cfg_q
);
    split_state_e state;
    logic         take;
    logic         fire;

    assign req_ready = (state == ST_IDLE);
    assign chk_valid = (state == ST_ISSUE);
    assign take      = req_valid && req_ready;
    assign fire      = chk_valid && chk_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            remain_dw <= '0;
            cfg_q     <= '0;
        end else if (take) begin
            cur_addr  <= {req_addr[ADDR_W-1:2], 2'b00};
            remain_dw <= req_len_dw;
            cfg_q     <= req_cfg;
            state     <= (req_len_dw == '0) ? ST_IDLE : ST_ISSUE;
        end else if (fire) begin
            cur_addr  <= cur_addr + (ADDR_W'(chunk_dw) << 2);
            remain_dw <= remain_dw - LEN_W'(chunk_dw);
            if (is_last)
                state <= ST_IDLE;
        end
    end
endmodule

// File: rtl/dma_req_splitter.sv
module dma_req_splitter
    import dma_split_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len_dw,
    input  logic                req_is_write,
    input  logic [CODE_W-1:0]   max_payload_code,
    input  logic [CODE_W-1:0]   max_read_code,
    output logic                chk_valid,
    input  logic                chk_ready,
    output logic [ADDR_W-1:0]   chk_addr,
    output logic [CHUNK_W-1:0]  chk_len_dw,
    output logic                chk_is_write,
    output logic                chk_last
);
    split_cfg_t        req_cfg;
    split_cfg_t        cfg_q;
    chunk_len_t        limit_dw;
    chunk_len_t        chunk_dw;
    logic              is_last;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain_dw;

    assign req_cfg = '{is_write: req_is_write,
                       payload_code: max_payload_code,
                       read_code: max_read_code};

    split_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len_dw (req_len_dw),
        .req_cfg    (req_cfg),
        .chk_ready  (chk_ready),
        .chunk_dw   (chunk_dw),
        .is_last    (is_last),
        .req_ready  (req_ready),
        .chk_valid  (chk_valid),
        .cur_addr   (cur_addr),
        .remain_dw  (remain_dw),
        .cfg_q      (cfg_q)
    );

    split_limit_sel i_limit (
        .cfg      (cfg_q),
        .limit_dw (limit_dw)
    );

    split_sizer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_sizer (
        .cur_addr  (cur_addr),
        .remain_dw (remain_dw),
        .limit_dw  (limit_dw),
        .chunk_dw  (chunk_dw),
        .is_last   (is_last)
    );

    assign chk_addr     = cur_addr;
    assign chk_len_dw   = chunk_dw;
    assign chk_is_write = cfg_q.is_write;
    assign chk_last     = is_last;
endmodule

// File: rtl/dma_req_splitter_chk.sv
module dma_req_splitter_chk
    import dma_split_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [LEN_W-1:0]   req_len_dw,
    input logic               chk_valid,
    input logic               chk_ready,
    input logic [ADDR_W-1:0]  chk_addr,
    input logic [CHUNK_W-1:0] chk_len_dw,
    input logic               chk_is_write,
    input logic               chk_last
);
    logic              fire;
    logic [ADDR_W-1:0] step;
    logic [CHUNK_W:0]  edge_sum;

    assign fire     = chk_valid && chk_ready;
    assign step     = ADDR_W'(chk_len_dw) << 2;
    assign edge_sum = (CHUNK_W+1)'(chk_addr[OFS_W+1:2]) + (CHUNK_W+1)'(chk_len_dw);

    a_r4_no_4k_cross: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> edge_sum <= (CHUNK_W+1)'(BOUNDARY_DW));

    a_r5_len_in_range: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> (chk_len_dw != '0) && (chk_len_dw <= CHUNK_W'(BOUNDARY_DW)));

    a_r6_addr_aligned: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> chk_addr[1:0] == 2'b00);

    a_r6_addr_advance: assert property (@(posedge clk) disable iff (rst)
        fire && !chk_last |=> chk_valid && (chk_addr == $past(chk_addr + step)));

    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        fire && chk_last |=> req_ready && !chk_valid);

    a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        chk_valid |-> !req_ready);

    a_r9_zero_len_idle: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_len_dw == '0) |=> req_ready && !chk_valid);

    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        chk_valid && !chk_ready |=> chk_valid && $stable(chk_addr)
            && $stable(chk_len_dw) && $stable(chk_last) && $stable(chk_is_write));

    a_r13_first_chunk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_len_dw != '0) |=> chk_valid);
endmodule

bind dma_req_splitter dma_req_splitter_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_len_dw   (req_len_dw),
    .chk_valid    (chk_valid),
    .chk_ready    (chk_ready),
    .chk_addr     (chk_addr),
    .chk_len_dw   (chk_len_dw),
    .chk_is_write (chk_is_write),
    .chk_last     (chk_last)
);

// File: tb/test_dma_req_splitter.sv
module test_dma_req_splitter;
    localparam int AW = 16;
    localparam int LW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len_dw = '0;
    logic          req_is_write = 1'b0;
    logic [2:0]    max_payload_code = '0;
    logic [2:0]    max_read_code = '0;
    logic          chk_valid;
    logic          chk_ready = 1'b0;
    logic [AW-1:0] chk_addr;
    logic [10:0]   chk_len_dw;
    logic          chk_is_write;
    logic          chk_last;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    dma_req_splitter #(.ADDR_W(AW), .LEN_W(LW)) i_dma_req_splitter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len_dw(req_len_dw), .req_is_write(req_is_write),
        .max_payload_code(max_payload_code), .max_read_code(max_read_code),
        .chk_valid(chk_valid), .chk_ready(chk_ready),
        .chk_addr(chk_addr), .chk_len_dw(chk_len_dw),
        .chk_is_write(chk_is_write), .chk_last(chk_last)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int cap_dw(input int code);
        return (code > 5) ? 1024 : (32 << code);
    endfunction

    task automatic run_req(input int addr, input int len, input bit wr,
                           input int pcode, input int rcode,
                           input bit noise, input int stall_pct);
        int  exp_addr;
        int  rem;
        int  lim;
        int  edge_dw;
        int  e;
        int  total;
        bit  last;
        bit  ready;
        bit  prev_stall;
        string tag;
        @(negedge clk);
        check(req_ready == 1'b1, "R8", "req_ready when idle", req_ready, 1);
        req_valid        = 1'b1;
        req_addr         = AW'(addr);
        req_len_dw       = LW'(len);
        req_is_write     = wr;
        max_payload_code = 3'(pcode);
        max_read_code    = 3'(rcode);
        chk_ready        = 1'b0;
        @(negedge clk);
        // R11: disturb captured settings; R8: noise on request inputs while busy
        max_payload_code = 3'(pcode + 3);
        max_read_code    = 3'(rcode + 5);
        if (noise) begin
            req_addr     = AW'(addr ^ 'h0444);
            req_len_dw   = LW'(7);
            req_is_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        if (len == 0) begin
            check(chk_valid == 1'b0, "R9", "chk_valid after zero length", chk_valid, 0);
            check(req_ready == 1'b1, "R9", "req_ready after zero length", req_ready, 1);
            req_valid = 1'b0;
            return;
        end
        exp_addr   = addr;
        rem        = len;
        total      = 0;
        lim        = wr ? cap_dw(pcode) : cap_dw(rcode);
        prev_stall = 0;
        while (rem > 0) begin
            edge_dw = 1024 - ((exp_addr >> 2) & 1023);
            e = rem;
            if (lim < e) e = lim;
            if (edge_dw < e) e = edge_dw;
            last = (e == rem);
            if (e == lim && e != rem) tag = wr ? "R2 R11" : "R3 R11";
            else if (e == edge_dw && e != rem) tag = "R4";
            else tag = "R5";
            check(chk_valid == 1'b1, prev_stall ? "R10" : "R13", "chk_valid", chk_valid, 1);
            check(chk_addr == AW'(exp_addr), prev_stall ? "R10" : "R6", "chk_addr", chk_addr, exp_addr);
            check(chk_len_dw == 11'(e), tag, "chk_len_dw", chk_len_dw, e);
            check(chk_last == last, "R7", "chk_last", chk_last, last);
            check(chk_is_write == wr, "R12", "chk_is_write", chk_is_write, wr);
            check(req_ready == 1'b0, "R8", "req_ready while busy", req_ready, 0);
            ready      = ($urandom_range(99) >= stall_pct);
            chk_ready  = ready;
            prev_stall = !ready;
            if (ready) begin
                if (last) req_valid = 1'b0;
                exp_addr += 4 * e;
                rem      -= e;
                total    += e;
            end
            @(negedge clk);
        end
        chk_ready = 1'b0;
        req_valid = 1'b0;
        check(total == len, "R7", "sum of chunk lengths", total, len);
        check(req_ready == 1'b1 && chk_valid == 1'b0, "R7", "idle after last",
              {req_ready, chk_valid}, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lens[8]  = '{0, 1, 31, 32, 33, 100, 1024, 1500};
        int addrs[5] = '{'h0000, 'h0FFC, 'h0F80, 'h0A04, 'h1234};
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        check(chk_valid == 1'b0, "R1", "chk_valid in reset", chk_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        check(chk_valid == 1'b0, "R1", "chk_valid after reset", chk_valid, 0);
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 8; c++) begin
                for (int li = 0; li < 8; li++) begin
                    for (int ai = 0; ai < 5; ai++) begin
                        run_req(addrs[ai], lens[li], d[0],
                                d[0] ? c : 7 - c, d[0] ? 7 - c : c,
                                ((li + ai) % 2) == 1, (ai * 20) % 60);
                    end
                end
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule